// File: doc/BRIEF.md
# CSR Instruction Execute Unit

This unit carries out the six atomic control-and-status-register instructions for one hardware thread. Each request carries a decoded function code, the destination and source register indices, the low bits of the source register value, and the 12-bit CSR specifier taken from instruction bits 31:20. The source index field also serves as the 5-bit immediate of the immediate forms. The unit decides from the register indices and the immediate field whether the CSR is read and whether it is written. It never looks at the operand value for this decision. It also decides whether the access is illegal.

In the request cycle the unit drives the specifier to a combinational CSR file port. From that port it takes the current value, an implemented flag and a writable-bit mask. The read strobe and the write strobe are issued in that same cycle, so the file commits the read-modify-write at a single clock edge. One cycle later the unit presents a registered result: valid, illegal flag, destination writeback enable, index, the old value zero-extended to the register width, and a serialize pulse. The pipeline uses that pulse to drain and refetch.

Top module: `csr_exec_unit`

## Requirements
- R1: Function codes are 001 swap, 010 set, 011 clear, 101 swap-immediate, 110 set-immediate and 111 clear-immediate. Codes 000 and 100 produce no strobe and no result: out_valid, out_illegal and out_serialize stay low.
- R2: Swap installs the operand as the new CSR value. When the CSR is read, the old value is returned on the writeback.
- R3: Set ORs the operand into the CSR and clear removes the operand bits (old AND NOT operand). The immediate forms use the 5-bit req_rs1 field, zero-extended, as the operand.
- R4: Swap and swap-immediate with destination index 0 issue no read strobe and no writeback, and they still issue the write strobe.
- R5: Set and clear forms always read. They write only when the source index or immediate field is nonzero, and this holds even when the source register value is zero.
- R6: A specifier with bits [11:10] equal to 2'b11 is read-only, and any access that writes it is illegal. A set or clear with source field 0 on such a CSR is legal.
- R7: An access to a specifier whose csr_impl input is low is illegal.
- R8: An access is illegal when cur_priv is below specifier bits [9:8].
- R9: An illegal access issues no read strobe, no write strobe and no writeback enable.
- R10: csr_wr_mask equals the writable mask. csr_wr_data equals (old AND NOT mask) OR (new AND mask), so non-writable bits keep their value.
- R11: The result registers update at the edge that ends the request cycle. out_wb_we is high exactly when the CSR was read legally with a nonzero destination index. out_wb_data is the old value zero-extended to XLEN bits.
- R12: The read strobe and the write strobe of one access fall in the same cycle, so the read-modify-write is atomic. Every handled request, legal or illegal, gives a one-cycle out_serialize pulse together with out_valid.
- R13: While rst_n is low, and in the cycle after it, all registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_func | input | 3 | Function code |
| req_rd | input | 5 | Destination register index |
| req_rs1 | input | 5 | Source register index or 5-bit immediate |
| req_src_val | input | CSR_W | Low CSR_W bits of the source register value |
| req_csr | input | 12 | CSR specifier |
| cur_priv | input | 2 | Current privilege level |
| csr_addr | output | 12 | Specifier presented to the CSR file |
| csr_rd_stb | output | 1 | CSR read strobe |
| csr_rdata | input | CSR_W | Current CSR value |
| csr_impl | input | 1 | Specifier is implemented |
| csr_writable | input | CSR_W | Writable-bit mask of the CSR |
| csr_wr_stb | output | 1 | CSR write strobe |
| csr_wr_data | output | CSR_W | Merged new CSR value |
| csr_wr_mask | output | CSR_W | Bits allowed to change |
| out_valid | output | 1 | Result of a handled request |
| out_illegal | output | 1 | Illegal-instruction flag |
| out_wb_we | output | 1 | Destination writeback enable |
| out_wb_rd | output | 5 | Destination index |
| out_wb_data | output | XLEN | Zero-extended old CSR value |
| out_serialize | output | 1 | Drain-and-refetch pulse |

## Verification
The properties assume that the CSR file answers combinationally within the request cycle. They also assume that csr_impl and csr_writable depend only on csr_addr, and that the request inputs are stable between clock edges. The bench holds a behavioural CSR file that meets these assumptions: it changes request inputs only on falling edges and commits writes only on rising edges. Stimulus covers every function code, including the two unhandled ones. It pairs source indices against source values so that a zero value under a nonzero index is exercised, and it mixes read-only, unimplemented, privilege-restricted and partly writable CSRs.

// File: rtl/csr_exec_pkg.sv
// Package: shared types of the CSR instruction execute unit.
// Assumes: function codes as listed in the brief (bit 2 = immediate form).
package csr_exec_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_SWAP = 2'b01,
        OP_SET  = 2'b10,
        OP_CLR  = 2'b11
    } csr_op_e;

    typedef struct packed {
        logic    handled;
        logic    use_imm;
        csr_op_e op;
        logic    do_read;
        logic    do_write;
    } csr_ctl_t;

    localparam int unsigned SPEC_W   = 12;
    localparam int unsigned IDX_W    = 5;
    localparam int unsigned PRIV_W   = 2;
    localparam int unsigned RO_HI    = 11;
    localparam int unsigned RO_LO    = 10;
    localparam int unsigned PRIV_HI  = 9;
    localparam int unsigned PRIV_LO  = 8;

endpackage

// File: rtl/csr_access_decode.sv
// Module: csr_access_decode
// Turns a function code and register index fields into the operation kind
// and the read/write decisions. Assumes: decisions depend only on index and
// immediate fields, never on any register value.
module csr_access_decode
    import csr_exec_pkg::*;
(
    input  logic [2:0]       func,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] rs1_idx,
    output csr_ctl_t         ctl
);

    // Decode operation kind, then read/write suppression from the index fields.
    always_comb begin
        ctl          = '0;
        ctl.use_imm  = func[2];
        unique case (func[1:0])
            2'b01:   ctl.op = OP_SWAP;
            2'b10:   ctl.op = OP_SET;
            2'b11:   ctl.op = OP_CLR;
            default: ctl.op = OP_NONE;
        endcase
        ctl.handled = (ctl.op != OP_NONE);
        if (ctl.op == OP_SWAP) begin
            ctl.do_read  = (rd_idx != '0);
            ctl.do_write = 1'b1;
        end else if (ctl.handled) begin
            ctl.do_read  = 1'b1;
            ctl.do_write = (rs1_idx != '0);
        end
    end

endmodule

// File: rtl/csr_trap_check.sv
// Module: csr_trap_check
// Flags an illegal access: unimplemented specifier, insufficient privilege,
// or a write to a read-only specifier. Assumes: the write decision is already
// suppressed according to the index fields.
module csr_trap_check
    import csr_exec_pkg::*;
(
    input  logic              handled,
    input  logic              do_write,
    input  logic [SPEC_W-1:0] spec,
    input  logic [PRIV_W-1:0] priv,
    input  logic              impl,
    output logic              illegal
);

    logic read_only;
    logic low_priv;

    // Classify the specifier and combine the three trap causes.
    always_comb begin
        read_only = (spec[RO_HI:RO_LO] == 2'b11);
        low_priv  = (priv < spec[PRIV_HI:PRIV_LO]);
        illegal   = handled & (~impl | low_priv | (do_write & read_only));
    end

endmodule

// File: rtl/csr_value_calc.sv
// Module: csr_value_calc
// Computes the new CSR value for swap, set or clear and merges it with the
// old value under the writable-bit mask. Assumes: operand is already
// selected (register value or zero-extended immediate).
module csr_value_calc
    import csr_exec_pkg::*;
#(
    parameter int unsigned CSR_W = 32
) (
    input  csr_op_e          op,
    input  logic [CSR_W-1:0] old_val,
    input  logic [CSR_W-1:0] operand,
    input  logic [CSR_W-1:0] writable,
    output logic [CSR_W-1:0] merged
);

    logic [CSR_W-1:0] raw_new;

    // Apply the operation, then keep non-writable bits from the old value.
    always_comb begin
        unique case (op)
            OP_SWAP: raw_new = operand;
            OP_SET:  raw_new = old_val | operand;
            OP_CLR:  raw_new = old_val & ~operand;
            default: raw_new = old_val;
        endcase
        merged = (old_val & ~writable) | (raw_new & writable);
    end

endmodule

// File: rtl/csr_exec_unit.sv
// Module: csr_exec_unit (top)
// Executes one CSR instruction per request cycle: strobes to a combinational
// CSR file port in the request cycle (atomic RMW at one edge), registered
// result one cycle later. Assumes: CSR file answers rdata/impl/writable
// combinationally from csr_addr; XLEN >= CSR_W.
module csr_exec_unit
    import csr_exec_pkg::*;
#(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned CSR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_func,
    input  logic [4:0]        req_rd,
    input  logic [4:0]        req_rs1,
    input  logic [CSR_W-1:0]  req_src_val,
    input  logic [11:0]       req_csr,
    input  logic [1:0]        cur_priv,
    output logic [11:0]       csr_addr,
    output logic              csr_rd_stb,
    input  logic [CSR_W-1:0]  csr_rdata,
    input  logic              csr_impl,
    input  logic [CSR_W-1:0]  csr_writable,
    output logic              csr_wr_stb,
    output logic [CSR_W-1:0]  csr_wr_data,
    output logic [CSR_W-1:0]  csr_wr_mask,
    output logic              out_valid,
    output logic              out_illegal,
    output logic              out_wb_we,
    output logic [4:0]        out_wb_rd,
    output logic [XLEN-1:0]   out_wb_data,
    output logic              out_serialize
);

    localparam int unsigned PAD_W = XLEN - CSR_W;
    localparam int unsigned IMM_PAD = CSR_W - IDX_W;

    csr_ctl_t         ctl;
    logic             illegal;
    logic [CSR_W-1:0] operand;
    logic [CSR_W-1:0] merged;

    csr_access_decode u_dec (
        .func    (req_func),
        .rd_idx  (req_rd),
        .rs1_idx (req_rs1),
        .ctl     (ctl)
    );

    csr_trap_check u_trap (
        .handled  (ctl.handled),
        .do_write (ctl.do_write),
        .spec     (req_csr),
        .priv     (cur_priv),
        .impl     (csr_impl),
        .illegal  (illegal)
    );

    // Select the register value or the zero-extended immediate as operand.
    always_comb begin
        operand = ctl.use_imm ? {{IMM_PAD{1'b0}}, req_rs1} : req_src_val;
    end

    csr_value_calc #(.CSR_W(CSR_W)) u_calc (
        .op       (ctl.op),
        .old_val  (csr_rdata),
        .operand  (operand),
        .writable (csr_writable),
        .merged   (merged)
    );

    // Drive the CSR file port; both strobes fall in the request cycle.
    always_comb begin
        csr_addr    = req_csr;
        csr_rd_stb  = req_valid & ctl.handled & ctl.do_read  & ~illegal;
        csr_wr_stb  = req_valid & ctl.handled & ctl.do_write & ~illegal;
        csr_wr_data = merged;
        csr_wr_mask = csr_writable;
    end

    // Register the result presented to writeback one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_illegal   <= 1'b0;
            out_wb_we     <= 1'b0;
            out_wb_rd     <= '0;
            out_wb_data   <= '0;
            out_serialize <= 1'b0;
        end else begin
            out_valid     <= req_valid & ctl.handled;
            out_illegal   <= req_valid & illegal;
            out_wb_we     <= csr_rd_stb & (req_rd != '0);
            out_wb_rd     <= req_rd;
            out_wb_data   <= csr_rd_stb ? {{PAD_W{1'b0}}, csr_rdata} : '0;
            out_serialize <= req_valid & ctl.handled;
        end
    end

endmodule

// File: rtl/csr_exec_chk.sv
// Module: csr_exec_chk
// Property checker bound to csr_exec_unit. Assumes: CSR file port is
// combinational and request inputs are stable between edges.
module csr_exec_chk #(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned CSR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_func,
    input logic [4:0]        req_rd,
    input logic [4:0]        req_rs1,
    input logic [CSR_W-1:0]  req_src_val,
    input logic [11:0]       req_csr,
    input logic [1:0]        cur_priv,
    input logic [11:0]       csr_addr,
    input logic              csr_rd_stb,
    input logic [CSR_W-1:0]  csr_rdata,
    input logic              csr_impl,
    input logic [CSR_W-1:0]  csr_writable,
    input logic              csr_wr_stb,
    input logic [CSR_W-1:0]  csr_wr_data,
    input logic [CSR_W-1:0]  csr_wr_mask,
    input logic              out_valid,
    input logic              out_illegal,
    input logic              out_wb_we,
    input logic [4:0]        out_wb_rd,
    input logic [XLEN-1:0]   out_wb_data,
    input logic              out_serialize
);

    AST_UNHANDLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_func[1:0] == 2'b00) |-> (!csr_rd_stb && !csr_wr_stb)); // R1

    AST_SWAP_RD0_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_func[1:0] == 2'b01 && req_rd == 5'd0) |-> !csr_rd_stb); // R4

    AST_SETCLR_IDX0_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_func[1] && req_rs1 == 5'd0) |-> !csr_wr_stb); // R5

    AST_NO_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr_stb |-> (csr_addr[11:10] != 2'b11)); // R6

    AST_UNIMPL_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_func[1:0] != 2'b00 && !csr_impl) |=> out_illegal); // R7

    AST_NO_STROBE_UNIMPL: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_impl |-> (!csr_rd_stb && !csr_wr_stb)); // R9

    AST_TRAP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> !out_wb_we); // R9

    AST_MASK_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr_stb |-> ((csr_wr_data & ~csr_writable) == (csr_rdata & ~csr_writable))); // R10

    AST_ZERO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wb_data >> CSR_W) == '0); // R11

    AST_SERIALIZE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_serialize == out_valid); // R12

endmodule

bind csr_exec_unit csr_exec_chk #(.XLEN(XLEN), .CSR_W(CSR_W)) u_chk (.*);

// File: tb/tb_csr_exec_unit.sv
// Bench: behavioural CSR file plus a behavioural reference model of the
// unit; every request cycle is compared on strobes, then on the result.
module tb_csr_exec_unit;

    localparam int XLEN  = 64;
    localparam int CSR_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [2:0]       req_func = '0;
    logic [4:0]       req_rd = '0;
    logic [4:0]       req_rs1 = '0;
    logic [31:0]      req_src_val = '0;
    logic [11:0]      req_csr = '0;
    logic [1:0]       cur_priv = '0;
    logic [11:0]      csr_addr;
    logic             csr_rd_stb;
    logic [31:0]      csr_rdata;
    logic             csr_impl;
    logic [31:0]      csr_writable;
    logic             csr_wr_stb;
    logic [31:0]      csr_wr_data;
    logic [31:0]      csr_wr_mask;
    logic             out_valid;
    logic             out_illegal;
    logic             out_wb_we;
    logic [4:0]       out_wb_rd;
    logic [63:0]      out_wb_data;
    logic             out_serialize;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] file_mem [0:4095];
    logic [31:0] ref_mem  [0:4095];

    always #2 clk = ~clk;

    csr_exec_unit #(.XLEN(XLEN), .CSR_W(CSR_W)) dut (.*);

    function automatic bit is_impl(input logic [11:0] a);
        return (a == 12'h300 || a == 12'h341 || a == 12'hC00 ||
                a == 12'hF11 || a == 12'h001);
    endfunction

    function automatic logic [31:0] wmask_of(input logic [11:0] a);
        case (a)
            12'h300: return 32'h8000_00FF;
            12'h341: return 32'hFFFF_FFFC;
            12'h001: return 32'hFFFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

    // Behavioural CSR file seen by the unit.
    assign csr_rdata    = file_mem[csr_addr];
    assign csr_impl     = is_impl(csr_addr);
    assign csr_writable = wmask_of(csr_addr);
    always @(posedge clk) if (csr_wr_stb) file_mem[csr_addr] <= csr_wr_data;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One request: drive at falling edge, check strobes mid-cycle,
    // then check the registered result in the following cycle.
    task automatic run(input string tag, input int fn, input int rd, input int rs1,
                       input logic [31:0] val, input logic [11:0] a, input int pv);
        bit handled, imm, rdq, wrq, ill, e_rd, e_wr;
        int kind;
        logic [31:0] opnd, old, nv, m, merged;
        req_valid = 1'b1; req_func = fn[2:0]; req_rd = rd[4:0]; req_rs1 = rs1[4:0];
        req_src_val = val; req_csr = a; cur_priv = pv[1:0];
        kind    = fn % 4;
        handled = (kind != 0);
        imm     = (fn >= 4);
        rdq     = (kind == 1) ? (rd != 0) : 1'b1;
        wrq     = (kind == 1) ? 1'b1 : (rs1 != 0);
        ill     = handled && (!is_impl(a) || (pv < int'(a[9:8])) ||
                              (wrq && a[11:10] == 2'b11));
        e_rd    = handled && rdq && !ill;
        e_wr    = handled && wrq && !ill;
        opnd    = imm ? 32'(rs1) : val;
        old     = ref_mem[a];
        m       = wmask_of(a);
        nv      = (kind == 1) ? opnd : (kind == 2) ? (old | opnd) : (old & ~opnd);
        merged  = (old & ~m) | (nv & m);
        #1;
        chk(ill ? "R9" : tag, "rd_stb", 64'(csr_rd_stb), 64'(e_rd));
        chk(ill ? "R9" : tag, "wr_stb", 64'(csr_wr_stb), 64'(e_wr));
        if (e_wr) begin
            chk("R10", "wr_data", 64'(csr_wr_data), 64'(merged));
            chk("R10", "wr_mask", 64'(csr_wr_mask), 64'(m));
            ref_mem[a] = merged;
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(handled ? tag : "R1", "valid", 64'(out_valid), 64'(handled));
        chk(tag, "illegal", 64'(out_illegal), 64'(ill));
        chk("R12", "serialize", 64'(out_serialize), 64'(handled));
        chk(ill ? "R9" : "R11", "wb_we", 64'(out_wb_we), 64'(e_rd && rd != 0));
        if (e_rd && rd != 0) begin
            chk(tag, "wb_data", out_wb_data, {32'h0, old});
            chk("R11", "wb_rd", 64'(out_wb_rd), 64'(rd));
        end
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            file_mem[i] = '0;
            ref_mem[i]  = '0;
        end
        file_mem[12'h300] = 32'h8000_0012; ref_mem[12'h300] = 32'h8000_0012;
        file_mem[12'hC00] = 32'h1234_5678; ref_mem[12'hC00] = 32'h1234_5678;
        file_mem[12'hF11] = 32'hDEAD_BEEF; ref_mem[12'hF11] = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        #1;
        chk("R13", "valid", 64'(out_valid), 64'd0);
        chk("R13", "wb_data", out_wb_data, 64'd0);
        chk("R13", "serialize", 64'(out_serialize), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run("R2", 1, 5, 9, 32'hFFFF_0F0F, 12'h300, 3);
        run("R5", 2, 6, 0, 32'hFFFF_FFFF, 12'h300, 3);
        run("R5", 2, 6, 7, 32'h0000_0000, 12'h300, 3);
        run("R6", 2, 7, 3, 32'h0000_0000, 12'hC00, 0);
        run("R6", 2, 7, 0, 32'h0000_0000, 12'hC00, 0);
        run("R4", 1, 0, 4, 32'h0000_1234, 12'h341, 3);
        run("R3", 2, 8, 1, 32'h0000_00F0, 12'h341, 3);
        run("R3", 3, 8, 2, 32'h0000_0030, 12'h341, 3);
        run("R3", 6, 9, 5'h1F, 32'hFFFF_FFFF, 12'h001, 0);
        run("R3", 7, 9, 5'h05, 32'hFFFF_FFFF, 12'h001, 0);
        run("R4", 5, 0, 5'h11, 32'h0, 12'h001, 0);
        run("R2", 5, 9, 5'h02, 32'h0, 12'h001, 0);
        run("R7", 1, 3, 1, 32'h5, 12'h7FF, 3);
        run("R7", 2, 3, 0, 32'h0, 12'h7FF, 3);
        run("R8", 2, 4, 0, 32'h0, 12'h300, 1);
        run("R8", 2, 4, 0, 32'h0, 12'hF11, 0);
        run("R8", 3, 4, 0, 32'h0, 12'hC00, 0);
        run("R1", 0, 4, 3, 32'hFFFF_FFFF, 12'h300, 3);
        run("R1", 4, 4, 3, 32'hFFFF_FFFF, 12'h300, 3);
        run("R10", 1, 2, 6, 32'hFFFF_FFFF, 12'h341, 3);
        run("R10", 2, 2, 0, 32'h0, 12'h341, 3);
        run("R11", 2, 0, 0, 32'h0, 12'h300, 3);
        run("R11", 2, 10, 0, 32'h0, 12'hF11, 3);
        run("R12", 3, 11, 5, 32'h8000_0000, 12'h300, 3);
        run("R12", 2, 11, 0, 32'h0, 12'h300, 3);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule